// File: doc/BRIEF.md
# Panned Scanout Address Generator

This block steps through an 8-bit-per-pixel frame store in raster order. For each pixel it presents one byte address, the pixel's column and row, a start-of-line flag and an end-of-frame flag. The downstream memory port acknowledges each pixel with `pix_adv_i`. Each frame's addresses are offset by a programmable top-of-screen base, so software scrolls the picture vertically by rewriting that one value. The new base takes effect only on a frame boundary, so a frame is never torn.

Width, height, base, depth code and the force-blank flag come from a register file outside the block. The byte read from memory enters on `pix_data_i` and leaves on `pix_o`. When blanking is forced, or when the depth code does not select 8 bits per pixel, that byte is replaced by zero. A level interrupt rises after each completed frame and stays high until the register file pulses `irq_clr_i`, which it does on any register write or on a soft reset.

Top module: `scan_addr_gen`

## Requirements
- R1: While scanout is active, `addr_o` equals (frame base + y*width + x) modulo 2^ADDR_W, one byte per pixel. The frame base is the top offset latched for the current frame.
- R2: Each `pix_adv_i` moves to the next pixel. When x = width-1, x returns to 0 and y increments. After the pixel (width-1, height-1), both x and y return to 0. Without `pix_adv_i`, x and y hold.
- R3: `sol_o` is high exactly when x = 0. `eof_o` is high exactly at pixel (width-1, height-1).
- R4: If width or height is zero, scanout stalls. `addr_valid_o` and `pix_valid_o` are low, `pix_adv_i` has no effect on x and y, and no interrupt is raised.
- R5: The top offset is sampled when the first pixel of a frame is consumed. A change made later in the frame applies from the first pixel of the next frame.
- R6: `irq_o` goes high on the clock edge that consumes the last pixel of a frame, and stays high until it is cleared.
- R7: `irq_clr_i` lowers `irq_o` on the next edge. If a frame completes on that same edge, the set wins.
- R8: `pix_valid_o` is high only while scanout is active and the depth code `depth_i` equals 3 (8 bits per pixel). Otherwise `pix_o` is 0.
- R9: While `blank_i` is 1, `pix_o` is 0. Addresses, markers, frames and interrupts continue unchanged.
- R10: After reset, x = y = 0, `irq_o` = 0, and the first frame uses the top offset present when its first pixel is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| width_i | input | DIM_W | Active pixels per line |
| height_i | input | DIM_W | Active lines per frame |
| top_i | input | ADDR_W | Top-of-screen byte offset |
| depth_i | input | 3 | Pixel depth code (3 = 8 bpp) |
| blank_i | input | 1 | Force blank |
| pix_adv_i | input | 1 | Current pixel consumed |
| irq_clr_i | input | 1 | Clear the frame interrupt |
| pix_data_i | input | 8 | Byte read at `addr_o` |
| addr_o | output | ADDR_W | Byte address of current pixel |
| addr_valid_o | output | 1 | Scanout active |
| x_o | output | DIM_W | Current column |
| y_o | output | DIM_W | Current row |
| sol_o | output | 1 | Start of line |
| eof_o | output | 1 | Last pixel of the frame |
| pix_valid_o | output | 1 | Pixel byte is rendered |
| pix_o | output | 8 | Rendered pixel index |
| irq_o | output | 1 | Frame-complete interrupt |

## Verification
The bench sweeps every width from 1 to 6 against every height from 1 to 4, so the single-pixel line, the single-line frame and the wrap from the last line back to row 0 are all covered. An off-by-one in the line or frame wrap would show up as a skipped or repeated row, or as a misplaced `eof_o`. A base changed in the middle of a frame is checked to land only on the next frame; a design that used the base live would jump addresses partway down the screen. Further cases check address wrap past the top of the 24-bit space, a stall in the middle of a frame through a zero height, blanking that keeps interrupts running, non-8-bit depth codes, and a clear pulse that coincides with frame completion.

// File: rtl/scan_pkg.sv
// Shared constants for the scanout address generator.
// Assumes pixel depth codes follow the 3-bit register encoding (3 = 8 bpp).
package scan_pkg;
    localparam logic [2:0] DEPTH_8BPP = 3'd3;
    localparam int         PIX_W      = 8;
endpackage

// File: rtl/scan_raster.sv
// Raster position counter: x/y plus the row byte offset y*width.
// Assumes adv_i is only asserted while width and height are nonzero.
module scan_raster #(
    parameter int DIM_W  = 12,
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    input  logic [DIM_W-1:0]  width_i,
    input  logic [DIM_W-1:0]  height_i,
    output logic [DIM_W-1:0]  x_o,
    output logic [DIM_W-1:0]  y_o,
    output logic [ADDR_W-1:0] row_off_o,
    output logic              last_x_o,
    output logic              last_pix_o
);
    logic [DIM_W-1:0] x_q, y_q;
    logic [ADDR_W-1:0] row_q;
    logic [ADDR_W-1:0] width_ext;

    // Widen width for the row-offset accumulator.
    assign width_ext  = ADDR_W'(width_i);
    // End-of-line and end-of-frame detection (>= tolerates a shrinking width).
    assign last_x_o   = (x_q >= width_i - 1'b1);
    assign last_pix_o = last_x_o && (y_q >= height_i - 1'b1);

    // Advance position one pixel per acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q   <= '0;
            y_q   <= '0;
            row_q <= '0;
        end else if (adv_i) begin
            if (last_pix_o) begin
                x_q   <= '0;
                y_q   <= '0;
                row_q <= '0;
            end else if (last_x_o) begin
                x_q   <= '0;
                y_q   <= y_q + 1'b1;
                row_q <= row_q + width_ext;
            end else begin
                x_q   <= x_q + 1'b1;
            end
        end
    end

    assign x_o       = x_q;
    assign y_o       = y_q;
    assign row_off_o = row_q;
endmodule

// File: rtl/scan_base.sv
// Frame base latch: samples the top offset as a frame's first pixel is consumed.
// Until then (fresh), the live top offset is used so pixel 0 agrees with the latch.
module scan_base #(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] top_i,
    input  logic              adv_i,
    input  logic              frame_done_i,
    output logic [ADDR_W-1:0] base_o
);
    logic              fresh_q;
    logic [ADDR_W-1:0] base_q;

    // Track whether the current frame has started, and latch its base.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fresh_q <= 1'b1;
            base_q  <= '0;
        end else if (adv_i) begin
            if (frame_done_i) begin
                fresh_q <= 1'b1;
            end else if (fresh_q) begin
                fresh_q <= 1'b0;
                base_q  <= top_i;
            end
        end
    end

    assign base_o = fresh_q ? top_i : base_q;
endmodule

// File: rtl/scan_irq.sv
// Level frame interrupt: set on frame completion, cleared by a register write.
// A set on the same edge as a clear wins.
module scan_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_o
);
    // Hold the interrupt level between set and clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     irq_o <= 1'b0;
        else if (set_i) irq_o <= 1'b1;
        else if (clr_i) irq_o <= 1'b0;
    end
endmodule

// File: rtl/scan_addr_gen.sv
// Panned scanout address generator for an 8 bpp frame store.
// Assumes one pixel per pix_adv_i acknowledge and single-byte pixels.
module scan_addr_gen
    import scan_pkg::*;
#(
    parameter int DIM_W  = 12,
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIM_W-1:0]  width_i,
    input  logic [DIM_W-1:0]  height_i,
    input  logic [ADDR_W-1:0] top_i,
    input  logic [2:0]        depth_i,
    input  logic              blank_i,
    input  logic              pix_adv_i,
    input  logic              irq_clr_i,
    input  logic [PIX_W-1:0]  pix_data_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              addr_valid_o,
    output logic [DIM_W-1:0]  x_o,
    output logic [DIM_W-1:0]  y_o,
    output logic              sol_o,
    output logic              eof_o,
    output logic              pix_valid_o,
    output logic [PIX_W-1:0]  pix_o,
    output logic              irq_o
);
    logic              active, adv, last_x, last_pix, frame_done;
    logic [ADDR_W-1:0] row_off, base;

    // Scanout runs only with a nonzero raster.
    assign active     = (width_i != '0) && (height_i != '0);
    assign adv        = active && pix_adv_i;
    assign frame_done = adv && last_pix;

    scan_raster #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_raster (
        .clk(clk), .rst_n(rst_n), .adv_i(adv),
        .width_i(width_i), .height_i(height_i),
        .x_o(x_o), .y_o(y_o), .row_off_o(row_off),
        .last_x_o(last_x), .last_pix_o(last_pix)
    );

    scan_base #(.ADDR_W(ADDR_W)) u_base (
        .clk(clk), .rst_n(rst_n), .top_i(top_i), .adv_i(adv),
        .frame_done_i(frame_done), .base_o(base)
    );

    scan_irq u_irq (
        .clk(clk), .rst_n(rst_n), .set_i(frame_done),
        .clr_i(irq_clr_i), .irq_o(irq_o)
    );

    // Address and markers for the current pixel.
    always_comb begin
        addr_o       = base + row_off + ADDR_W'(x_o);
        addr_valid_o = active;
        sol_o        = active && (x_o == '0);
        eof_o        = active && last_pix;
    end

    // Pixel gating by depth and force-blank.
    always_comb begin
        pix_valid_o = active && (depth_i == DEPTH_8BPP);
        pix_o       = (pix_valid_o && !blank_i) ? pix_data_i : '0;
    end
endmodule

// File: rtl/scan_addr_gen_chk.sv
// Property checker for scan_addr_gen, attached by bind.
module scan_addr_gen_chk #(
    parameter int DIM_W  = 12,
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DIM_W-1:0]  width_i,
    input logic [DIM_W-1:0]  height_i,
    input logic [2:0]        depth_i,
    input logic              blank_i,
    input logic              pix_adv_i,
    input logic              irq_clr_i,
    input logic              addr_valid_o,
    input logic [DIM_W-1:0]  x_o,
    input logic [DIM_W-1:0]  y_o,
    input logic              eof_o,
    input logic              pix_valid_o,
    input logic [7:0]        pix_o,
    input logic              irq_o
);
    a_r2_hold_without_adv: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_adv_i |=> $stable({x_o, y_o}));
    a_r2_frame_wraps: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_adv_i && eof_o) |=> (x_o == '0 && y_o == '0));
    a_r4_stall_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        (width_i == '0 || height_i == '0) |-> !addr_valid_o);
    a_r6_irq_on_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_adv_i && eof_o) |=> irq_o);
    a_r6_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(pix_adv_i && eof_o));
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr_i && !(pix_adv_i && eof_o)) |=> !irq_o);
    a_r8_depth_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (depth_i != 3'd3) |-> (!pix_valid_o && pix_o == '0));
    a_r9_blank_zero: assert property (@(posedge clk) disable iff (!rst_n)
        blank_i |-> (pix_o == '0));
endmodule

bind scan_addr_gen scan_addr_gen_chk #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .width_i(width_i), .height_i(height_i),
    .depth_i(depth_i), .blank_i(blank_i), .pix_adv_i(pix_adv_i),
    .irq_clr_i(irq_clr_i), .addr_valid_o(addr_valid_o), .x_o(x_o), .y_o(y_o),
    .eof_o(eof_o), .pix_valid_o(pix_valid_o), .pix_o(pix_o), .irq_o(irq_o)
);

// File: tb/scan_addr_gen_tb.sv
module scan_addr_gen_tb;
    localparam int DIM_W  = 12;
    localparam int ADDR_W = 24;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [DIM_W-1:0]  width_i = '0, height_i = '0;
    logic [ADDR_W-1:0] top_i = '0;
    logic [2:0]        depth_i = 3'd3;
    logic              blank_i = 1'b0, pix_adv_i = 1'b0, irq_clr_i = 1'b0;
    logic [7:0]        pix_data_i = '0;
    logic [ADDR_W-1:0] addr_o;
    logic              addr_valid_o, sol_o, eof_o, pix_valid_o, irq_o;
    logic [DIM_W-1:0]  x_o, y_o;
    logic [7:0]        pix_o;

    int n_chk = 0, n_bad = 0;

    always #2 clk = ~clk;

    scan_addr_gen #(.DIM_W(DIM_W), .ADDR_W(ADDR_W)) u_dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Scan one frame; top2/at_pix model a mid-frame top change.
    task automatic run_frame(input int w, input int h, input logic [ADDR_W-1:0] top,
                             input logic [ADDR_W-1:0] top2, input int at_pix,
                             input bit blank, input bit depth_ok);
        int k = 0;
        top_i = top; blank_i = blank;
        for (int y = 0; y < h; y++) begin
            for (int x = 0; x < w; x++) begin
                @(negedge clk);
                pix_data_i = 8'(x * 13 + y * 7 + 1);
                if (k == at_pix) top_i = top2;
                #0.1;
                chk("R1 addr", 32'(addr_o), 32'(ADDR_W'(top + y * w + x)));
                chk("R2 x", 32'(x_o), x);
                chk("R2 y", 32'(y_o), y);
                chk("R3 sol", 32'(sol_o), (x == 0));
                chk("R3 eof", 32'(eof_o), (x == w - 1 && y == h - 1));
                chk("R8 pix_valid", 32'(pix_valid_o), depth_ok);
                chk("R9 pix", 32'(pix_o),
                    (depth_ok && !blank) ? 32'(8'(x * 13 + y * 7 + 1)) : 0);
                pix_adv_i = 1'b1;
                k++;
            end
        end
        @(negedge clk);
        pix_adv_i = 1'b0;
        chk("R6 irq set after frame", 32'(irq_o), 1);
        irq_clr_i = 1'b1;
        @(negedge clk);
        irq_clr_i = 1'b0;
        chk("R7 irq cleared", 32'(irq_o), 0);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                // R10 reset state
                chk("R10 x", 32'(x_o), 0);
                chk("R10 y", 32'(y_o), 0);
                chk("R10 irq", 32'(irq_o), 0);
                chk("R4 stall at zero size", 32'(addr_valid_o), 0);

                // R1 R2 R3 exhaustive small sweep
                for (int w = 1; w <= 6; w++)
                    for (int h = 1; h <= 4; h++) begin
                        width_i = DIM_W'(w); height_i = DIM_W'(h);
                        run_frame(w, h, ADDR_W'(w * 100 + h), ADDR_W'(w * 100 + h), -1, 0, 1);
                    end

                // R5 mid-frame top change
                width_i = 4; height_i = 3;
                run_frame(4, 3, 24'h000200, 24'h000900, 5, 0, 1);
                run_frame(4, 3, 24'h000900, 24'h000900, -1, 0, 1);

                // R1 modulo wrap of the address space
                run_frame(4, 3, 24'hFFFFFA, 24'hFFFFFA, -1, 0, 1);

                // R9 blank keeps frames and interrupts
                run_frame(4, 3, 24'h10, 24'h10, -1, 1, 1);

                // R8 other depth codes
                depth_i = 3'd2;
                run_frame(4, 3, 24'h20, 24'h20, -1, 0, 0);
                depth_i = 3'd5;
                run_frame(4, 3, 24'h20, 24'h20, -1, 0, 0);
                depth_i = 3'd3;

                // R4 mid-frame stall via zero height
                top_i = 24'h40;
                repeat (5) begin @(negedge clk); pix_adv_i = 1'b1; end
                @(negedge clk); pix_adv_i = 1'b0;
                height_i = '0;
                repeat (12) begin
                    @(negedge clk); pix_adv_i = 1'b1;
                    #0.1;
                    chk("R4 addr_valid low", 32'(addr_valid_o), 0);
                end
                @(negedge clk); pix_adv_i = 1'b0;
                chk("R4 no irq in stall", 32'(irq_o), 0);
                height_i = 3;
                #0.1;
                chk("R4 x held", 32'(x_o), 1);
                chk("R4 y held", 32'(y_o), 1);
                chk("R1 addr after stall", 32'(addr_o), 32'h40 + 5);
                // finish that frame: 7 more pixels
                repeat (7) begin @(negedge clk); pix_adv_i = 1'b1; end
                @(negedge clk); pix_adv_i = 1'b0;
                chk("R6 irq after resumed frame", 32'(irq_o), 1);

                // R7 clear coinciding with frame completion: set wins
                width_i = 1; height_i = 1;
                @(negedge clk);
                pix_adv_i = 1'b1; irq_clr_i = 1'b1;
                @(negedge clk);
                pix_adv_i = 1'b0; irq_clr_i = 1'b0;
                chk("R7 set wins over clear", 32'(irq_o), 1);
                irq_clr_i = 1'b1;
                @(negedge clk); irq_clr_i = 1'b0;
                chk("R7 clear", 32'(irq_o), 0);

                // R10 reset mid-frame
                width_i = 4; height_i = 3;
                repeat (3) begin @(negedge clk); pix_adv_i = 1'b1; end
                @(negedge clk); pix_adv_i = 1'b0; rst_n = 1'b0;
                @(negedge clk); rst_n = 1'b1;
                chk("R10 x after reset", 32'(x_o), 0);
                chk("R10 y after reset", 32'(y_o), 0);
            end
            begin
                repeat (150000) @(negedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule